// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down counters behind a byte-wide register bus with a 2-bit address. Addresses 0, 1 and 2 reach the count of channel 0, 1 and 2. Address 3 takes a command byte. The command byte names a channel and sets four things for it: how its count is moved over the byte bus, its counting mode, and whether it counts in binary or in packed BCD. The same port also accepts a latch command. This command freezes a snapshot of a running count, so the count can be read without stopping the channel.

Each channel has its own clock-enable, gate and output. One enabled cycle is one count tick. Three modes are built. In terminal-count mode the output rises once when the count reaches zero. In rate mode the output goes low for one tick in every N. In square mode the output toggles every half period. A typical use is a periodic tick or tone generator. For a wanted frequency f, the divisor is the count clock divided by f, rounded to the nearest integer.

Top module: `tri_interval_timer`

## Requirements
- R1: A write to address 3 is decoded as follows. Bits [7:6] select the channel (0, 1 or 2). Bits [5:4] select the access pattern: 00 latch, 01 low byte only, 10 high byte only, 11 low byte then high byte. Bits [3:1] give the mode. Bit 0 selects BCD. A non-latch command stops the channel, resets both of its byte flip-flops to the low byte and drops any pending latch. It drives the output low in terminal-count mode and high in the other two modes.
- R2: Count writes depend on the access pattern. Low-byte-only loads {8'h00, data}. High-byte-only loads {data, 8'h00}. The two-byte pattern takes the low byte and then the high byte, and the count takes effect only after the second byte. The loaded value is moved into the counter on the next cycle in which that channel's clock-enable is high.
- R3: Count reads return the low byte for pattern 01 and the high byte for pattern 10. For pattern 11 the reads alternate low then high, and each channel keeps its own read flip-flop.
- R4: A latch command copies the channel's count into a holding register. It does not change the mode or the access pattern. Reads then return the held value until it has been fully read under the current pattern. A second latch command issued before then is ignored.
- R5: In terminal-count mode the output is low from the command write onward. After the load tick it rises on the N-th decrement tick. It then stays high until a new count is written.
- R6: In rate mode the period is N ticks. The output is low only while the count equals 1, and the counter then reloads N.
- R7: In square mode the output is high for ceil(N/2) ticks and low for floor(N/2) ticks, starting high at the load tick.
- R8: While a channel's gate is low its count does not decrement in any mode. In rate and square mode its output is also held high.
- R9: With BCD selected the count steps through four decimal digits (0x0010 goes to 0x0009). A loaded count of 0 acts as 10000 in BCD, so the next tick gives 0x9999. In binary it acts as 65536, so the next tick gives 0xFFFF.
- R10: Mode codes 1, 4 and 5 behave as terminal-count mode, and codes 6 and 7 behave as 2 and 3. A command with channel field 11 has no effect. Reading address 3 returns 0.
- R11: After reset every output is high, every count reads 0 and every channel uses the two-byte pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address: 0-2 channel counts, 3 command |
| wrEn | input | 1 | Write strobe for one cycle |
| rdEn | input | 1 | Read strobe; advances read flip-flop and latch release |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte for the current address |
| cntEn | input | 3 | Per-channel count clock-enable, one tick per high cycle |
| gate | input | 3 | Per-channel gate; low suspends counting |
| tmrOut | output | 3 | Per-channel timer output |

## Verification
The hardest state to reach is a latched snapshot that has to survive while the live count keeps moving and a second latch command arrives. The bench reaches this state by loading a known count and then issuing exact numbers of single-cycle enable pulses, so the snapshot and the live value are both known numbers. Output waveforms are swept over every mode code, divisors from 2 to 9, both number bases and all three channels. Each sample is compared with the period formula for its mode.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int NUM_CH = 3;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int DIGITS = CNT_W / 4;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } accessT;

  typedef enum logic [1:0] {
    CM_TERM   = 2'b00,
    CM_RATE   = 2'b01,
    CM_SQUARE = 2'b10
  } chanModeT;

  typedef struct packed {
    logic             cfgWr;
    chanModeT         mode;
    logic             bcd;
    logic             cntWr;
    logic [CNT_W-1:0] cntVal;
  } chanStrobeT;

  function automatic chanModeT decodeMode(input logic [2:0] m);
    case (m[1:0])
      2'b10:   return CM_RATE;
      2'b11:   return CM_SQUARE;
      default: return CM_TERM;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] decOne(input logic [CNT_W-1:0] v, input logic bcd);
    logic [CNT_W-1:0] r;
    logic borrow;
    r = v;
    borrow = 1'b1;
    if (!bcd) begin
      r = v - 1'b1;
    end else begin
      for (int d = 0; d < DIGITS; d++) begin
        if (borrow) begin
          if (r[d*4 +: 4] == 4'd0) r[d*4 +: 4] = 4'd9;
          else begin
            r[d*4 +: 4] = r[d*4 +: 4] - 4'd1;
            borrow = 1'b0;
          end
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [1:0]                       addr,
  input  logic                             wrEn,
  input  logic                             rdEn,
  input  logic [BYTE_W-1:0]                wrData,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     liveCount,
  output chanStrobeT [NUM_CH-1:0]          strobe,
  output logic [BYTE_W-1:0]                rdData
);
  logic   ctrlWr;
  accessT accField;
  logic [BYTE_W-1:0] rdByte [NUM_CH];

  assign ctrlWr   = wrEn && (addr == 2'd3);
  assign accField = accessT'(wrData[5:4]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    accessT accQ;
    logic wrHiQ, rdHiQ, latchedQ;
    logic [BYTE_W-1:0] lowByteQ;
    logic [CNT_W-1:0]  holdQ, viewVal;
    logic isCfg, isLatchCmd, portWr, portRd, lastRd;

    assign isCfg      = ctrlWr && (wrData[7:6] == 2'(i)) && (accField != ACC_LATCH);
    assign isLatchCmd = ctrlWr && (wrData[7:6] == 2'(i)) && (accField == ACC_LATCH);
    assign portWr     = wrEn && (addr == 2'(i));
    assign portRd     = rdEn && (addr == 2'(i));
    assign lastRd     = (accQ != ACC_WORD) || rdHiQ;

    assign strobe[i].cfgWr = isCfg;
    assign strobe[i].mode  = decodeMode(wrData[3:1]);
    assign strobe[i].bcd   = wrData[0];
    assign strobe[i].cntWr = portWr && ((accQ != ACC_WORD) || wrHiQ);
    always_comb begin
      case (accQ)
        ACC_LO:  strobe[i].cntVal = {{BYTE_W{1'b0}}, wrData};
        ACC_HI:  strobe[i].cntVal = {wrData, {BYTE_W{1'b0}}};
        default: strobe[i].cntVal = {wrData, lowByteQ};
      endcase
    end

    assign viewVal   = latchedQ ? holdQ : liveCount[i];
    assign rdByte[i] = ((accQ == ACC_HI) || ((accQ == ACC_WORD) && rdHiQ))
                       ? viewVal[CNT_W-1:BYTE_W] : viewVal[BYTE_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        accQ     <= ACC_WORD;
        wrHiQ    <= 1'b0;
        rdHiQ    <= 1'b0;
        latchedQ <= 1'b0;
        lowByteQ <= '0;
        holdQ    <= '0;
      end else if (isCfg) begin
        accQ     <= accField;
        wrHiQ    <= 1'b0;
        rdHiQ    <= 1'b0;
        latchedQ <= 1'b0;
      end else begin
        if (isLatchCmd && !latchedQ) begin
          latchedQ <= 1'b1;
          holdQ    <= liveCount[i];
        end
        if (portWr && (accQ == ACC_WORD)) begin
          wrHiQ <= !wrHiQ;
          if (!wrHiQ) lowByteQ <= wrData;
        end
        if (portRd) begin
          if (accQ == ACC_WORD) rdHiQ <= !rdHiQ;
          if (lastRd) latchedQ <= 1'b0;
        end
      end
    end

    // R1: a command write returns both byte flip-flops to the low byte
    p_flip_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      isCfg |=> (!wrHiQ && !rdHiQ));
    // R4: a held snapshot is not replaced by a repeated latch or by counting
    p_hold_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (latchedQ && !isCfg && !portRd) |=> (latchedQ && $stable(holdQ)));
  end

  always_comb begin
    rdData = '0;
    for (int j = 0; j < NUM_CH; j++)
      if (addr == 2'(j)) rdData = rdByte[j];
  end
endmodule

// File: rtl/pit_chan.sv
module pit_chan
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  chanStrobeT       strobe,
  input  logic             cntEn,
  input  logic             gate,
  output logic [CNT_W-1:0] count,
  output logic             tmrOut
);
  chanModeT modeQ;
  logic bcdQ, outQ, pendQ, runQ;
  logic [CNT_W-1:0] reloadQ, countQ, d1, d2, d3, sqNext;
  logic [1:0] sqStep;
  logic tick, loadNow, sqHit, quiet;

  assign tick    = cntEn && gate && runQ && !pendQ;
  assign loadNow = cntEn && pendQ;
  assign quiet   = !strobe.cfgWr && !strobe.cntWr;

  assign d1 = decOne(countQ, bcdQ);
  assign d2 = decOne(d1, bcdQ);
  assign d3 = decOne(d2, bcdQ);

  // Square mode: an odd count spends one extra tick high, one fewer low
  assign sqStep = !countQ[0] ? 2'd2 : (outQ ? 2'd1 : 2'd3);
  assign sqHit  = (countQ == CNT_W'(sqStep));
  assign sqNext = (sqStep == 2'd1) ? d1 : ((sqStep == 2'd2) ? d2 : d3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ   <= CM_TERM;
      bcdQ    <= 1'b0;
      outQ    <= 1'b1;
      pendQ   <= 1'b0;
      runQ    <= 1'b0;
      reloadQ <= '0;
      countQ  <= '0;
    end else if (strobe.cfgWr) begin
      modeQ <= strobe.mode;
      bcdQ  <= strobe.bcd;
      outQ  <= (strobe.mode != CM_TERM);
      runQ  <= 1'b0;
      pendQ <= 1'b0;
    end else if (strobe.cntWr) begin
      reloadQ <= strobe.cntVal;
      pendQ   <= 1'b1;
      if (modeQ == CM_TERM) outQ <= 1'b0;
    end else if (loadNow) begin
      countQ <= reloadQ;
      pendQ  <= 1'b0;
      runQ   <= 1'b1;
      if (modeQ == CM_SQUARE) outQ <= 1'b1;
    end else if (tick) begin
      case (modeQ)
        CM_RATE: countQ <= (countQ == CNT_W'(1)) ? reloadQ : d1;
        CM_SQUARE: begin
          if (sqHit) begin
            countQ <= reloadQ;
            outQ   <= !outQ;
          end else begin
            countQ <= sqNext;
          end
        end
        default: begin
          countQ <= d1;
          if (countQ == CNT_W'(1)) outQ <= 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    if ((modeQ != CM_TERM) && !gate)                            tmrOut = 1'b1;
    else if ((modeQ == CM_RATE) && runQ && (countQ == CNT_W'(1))) tmrOut = 1'b0;
    else                                                          tmrOut = outQ;
  end
  assign count = countQ;

  // R1: a terminal-count command drives the output low
  p_cfg_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.cfgWr && (strobe.mode == CM_TERM)) |=> !tmrOut);
  // R5: once high in terminal-count mode, the output holds until rewritten
  p_term_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((modeQ == CM_TERM) && outQ && quiet) |=> outQ);
  // R6: the tick at count 1 brings back the reload value
  p_rate_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((modeQ == CM_RATE) && tick && (countQ == CNT_W'(1)) && quiet) |=> (countQ == $past(reloadQ)));
  // R7: the square output only changes at a half-period boundary
  p_square_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((modeQ == CM_SQUARE) && tick && !sqHit && quiet) |=> $stable(outQ));
  // R8: a low gate freezes the count
  p_gate_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate && quiet && !loadNow) |=> $stable(countQ));
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
  import pit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  addr,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic [2:0]  cntEn,
  input  logic [2:0]  gate,
  output logic [2:0]  tmrOut
);
  chanStrobeT [NUM_CH-1:0]      strobe;
  logic [NUM_CH-1:0][CNT_W-1:0] liveCount;

  pit_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .wrData   (wrData),
    .liveCount(liveCount),
    .strobe   (strobe),
    .rdData   (rdData)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    pit_chan u_chan (
      .clk   (clk),
      .rst_n (rst_n),
      .strobe(strobe[i]),
      .cntEn (cntEn[i]),
      .gate  (gate[i]),
      .count (liveCount[i]),
      .tmrOut(tmrOut[i])
    );
  end
endmodule

// File: tb/tri_interval_timer_bench.sv
module tri_interval_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0, rdData;
  logic [2:0] cntEn = '0, gate = 3'b111, tmrOut;
  int total = 0, bad = 0;

  tri_interval_timer u_tri_interval_timer (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .cntEn(cntEn), .gate(gate), .tmrOut(tmrOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic rdWord(input logic [1:0] ch, output logic [15:0] w);
    logic [7:0] lo, hi;
    rdReg(ch, lo);
    rdReg(ch, hi);
    w = {hi, lo};
  endtask

  task automatic pulseEn(input int ch, input int n);
    for (int p = 0; p < n; p++) begin
      @(negedge clk); cntEn[ch] = 1'b1;
      @(negedge clk); cntEn[ch] = 1'b0;
    end
  endtask

  // command byte: channel[7:6], access[5:4], mode[3:1], bcd[0]
  function automatic logic [7:0] cmd(input int ch, input int acc, input int mode, input bit bcd);
    return {2'(ch), 2'(acc), 3'(mode), bcd};
  endfunction

  task automatic sweepRun(input int ch, input int code, input int n, input bit bcd);
    int eff;
    bit exp;
    eff = (code == 2 || code == 6) ? 2 : ((code == 3 || code == 7) ? 3 : 0);
    wrReg(2'd3, cmd(ch, 1, code, bcd));
    wrReg(2'(ch), 8'(n));
    if (eff == 0) chk("R1/R5 low after command", int'(tmrOut[ch]), 0);
    cntEn[ch] = 1'b1;
    for (int k = 1; k <= 3 * n; k++) begin
      @(negedge clk);
      if (eff == 0)      exp = (k >= n + 1);
      else if (eff == 2) exp = !((k >= n) && ((k - n) % n == 0));
      else               exp = (((k - 1) % n) < ((n + 1) / 2));
      chk(eff == 0 ? "R5/R10 term-count output" : (eff == 2 ? "R6/R10 rate output" : "R7/R10 square output"),
          int'(tmrOut[ch]), int'(exp));
    end
    cntEn[ch] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    chk("R11 outputs high", int'(tmrOut), 7);
    rdWord(2'd0, w); chk("R11 count zero, word access", int'(w), 0);

    // R2/R3: two-byte load, per-channel read flip-flops
    wrReg(2'd3, cmd(0, 3, 0, 0));
    wrReg(2'd3, cmd(1, 3, 0, 0));
    wrReg(2'd0, 8'h34);
    pulseEn(0, 1);
    chk("R2 no load before second byte", int'(tmrOut[0]), 0);
    wrReg(2'd0, 8'h12);
    wrReg(2'd1, 8'h78); wrReg(2'd1, 8'h56);
    pulseEn(0, 1); pulseEn(1, 1);
    rdReg(2'd0, b); chk("R3 ch0 low byte", int'(b), 'h34);
    rdReg(2'd1, b); chk("R3 ch1 low byte", int'(b), 'h78);
    rdReg(2'd0, b); chk("R3 ch0 high byte", int'(b), 'h12);
    rdReg(2'd1, b); chk("R3 ch1 high byte", int'(b), 'h56);

    // R1: command resets write flip-flop mid-pair
    wrReg(2'd3, cmd(0, 3, 2, 0));
    wrReg(2'd0, 8'hEE);
    wrReg(2'd3, cmd(0, 3, 2, 0));
    wrReg(2'd0, 8'h05); wrReg(2'd0, 8'h00);
    pulseEn(0, 1);
    rdWord(2'd0, w); chk("R1 flip-flop reset on command", int'(w), 5);

    // R2: low-only and high-only loads
    wrReg(2'd3, cmd(2, 1, 0, 0)); wrReg(2'd2, 8'hAB); pulseEn(2, 1);
    rdReg(2'd2, b); chk("R2 low-only low byte", int'(b), 'hAB);
    wrReg(2'd3, cmd(2, 2, 0, 0)); rdReg(2'd2, b); chk("R2 low-only high byte zero", int'(b), 0);
    wrReg(2'd2, 8'hCD); pulseEn(2, 1);
    rdReg(2'd2, b); chk("R3 high-only read", int'(b), 'hCD);
    wrReg(2'd3, cmd(2, 1, 0, 0)); rdReg(2'd2, b); chk("R2 high-only low byte zero", int'(b), 0);

    // R4: latch holds while counting, second latch ignored, release after pair
    wrReg(2'd3, cmd(1, 3, 2, 0));
    wrReg(2'd1, 8'h00); wrReg(2'd1, 8'h01);
    pulseEn(1, 1); pulseEn(1, 4);
    wrReg(2'd3, cmd(1, 0, 0, 0));
    pulseEn(1, 3);
    wrReg(2'd3, cmd(1, 0, 0, 0));
    pulseEn(1, 3);
    rdReg(2'd1, b); chk("R4 held low byte", int'(b), 'hFC);
    pulseEn(1, 2);
    rdReg(2'd1, b); chk("R4 held high byte", int'(b), 'h00);
    rdWord(2'd1, w); chk("R4 released to live count", int'(w), 'h100 - 12);
    chk("R4 latch keeps rate mode", int'(tmrOut[1]), 1);

    // R8: gate freezes count, forces output high
    wrReg(2'd3, cmd(0, 3, 2, 0));
    wrReg(2'd0, 8'h50); wrReg(2'd0, 8'h00);
    pulseEn(0, 1); pulseEn(0, 4);
    gate[0] = 1'b0;
    pulseEn(0, 5);
    rdWord(2'd0, w); chk("R8 count frozen by gate", int'(w), 'h4C);
    gate[0] = 1'b1;
    wrReg(2'd3, cmd(0, 1, 3, 0)); wrReg(2'd0, 8'd4);
    pulseEn(0, 1); pulseEn(0, 2);
    chk("R7 square in low phase", int'(tmrOut[0]), 0);
    gate[0] = 1'b0; #1;
    chk("R8 gate low forces high", int'(tmrOut[0]), 1);
    gate[0] = 1'b1;

    // R9: zero counts and BCD borrow
    wrReg(2'd3, cmd(2, 3, 2, 0)); wrReg(2'd2, 8'h00); wrReg(2'd2, 8'h00);
    pulseEn(2, 2);
    rdWord(2'd2, w); chk("R9 binary zero is 65536", int'(w), 'hFFFF);
    wrReg(2'd3, cmd(2, 3, 0, 1)); wrReg(2'd2, 8'h00); wrReg(2'd2, 8'h00);
    pulseEn(2, 2);
    rdWord(2'd2, w); chk("R9 BCD zero is 10000", int'(w), 'h9999);
    wrReg(2'd3, cmd(2, 3, 0, 1)); wrReg(2'd2, 8'h12); wrReg(2'd2, 8'h00);
    pulseEn(2, 1); pulseEn(2, 2);
    rdWord(2'd2, w); chk("R9 BCD borrow across digit", int'(w), 'h0010);
    pulseEn(2, 9);
    chk("R5 low before terminal", int'(tmrOut[2]), 0);
    pulseEn(2, 1);
    chk("R5 high at terminal", int'(tmrOut[2]), 1);
    wrReg(2'd2, 8'h03); wrReg(2'd2, 8'h00);
    chk("R5 rewrite drops output", int'(tmrOut[2]), 0);

    // R10: channel field 11 ignored, address 3 reads zero
    wrReg(2'd3, 8'hD6);
    chk("R10 select 11 no effect", int'(tmrOut[2]), 0);
    rdReg(2'd3, b); chk("R10 address 3 reads zero", int'(b), 0);

    // R5/R6/R7/R10: sweep over channels, mode codes, divisors and bases
    for (int ch = 0; ch < 3; ch++)
      for (int code = 0; code < 8; code++)
        for (int n = 2; n < 10; n++)
          for (int bb = 0; bb < 2; bb++)
            sweepRun(ch, code, n, bb[0]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule